// File: doc/BRIEF.md
# Interrupt Entry Microsequencer

This block carries out the entry half of a software interrupt for a 16-bit segmented processor whose memory port moves one byte at a time. A request brings the interrupt type, the flags word, the code segment, the address of the interrupt instruction, and the stack segment and stack pointer. The block saves the return context on the stack as three words, then reads the two-word vector for the requested type and reports the new code segment, new instruction pointer and new stack pointer together with a one-cycle completion pulse.

Every memory access takes one state. The six stack byte writes come first, then the four vector byte reads. Physical addresses are formed as segment times sixteen plus offset, truncated to 20 bits. The surrounding core decodes the instruction, applies any flag changes and handles the return path. This block does none of those.

Top module: `int_entry_seq`

## Requirements
- R1: While reset is held, and whenever the block is idle, `busy`, `done`, `mem_wr` and `mem_rd` are all low.
- R2: A request with `req_valid` high on a clock edge while idle is accepted on that edge, and `busy` is high in the following cycle.
- R3: The six stack writes use the offsets SP-1, SP-2, SP-3, SP-4, SP-5 and SP-6, in that order, one write per cycle. Each offset is computed modulo 2^16. The writes start the cycle after acceptance. This is the pre-decrement rule: each word is stored below the pointer.
- R4: The word at SP-2 holds the flags, the word at SP-4 holds the code segment, and the word at SP-6 holds the instruction address plus 2. Each word is little-endian, with the low byte at the lower address. The high byte of each word is written first.
- R5: Every memory address is (segment << 4) + offset, taken modulo 2^20. Stack accesses use the stack segment. Vector reads use segment 0.
- R6: After the last stack write, four reads follow on consecutive cycles at byte addresses 4n, 4n+1, 4n+2 and 4n+3, where n is the 8-bit type. Read data is taken from `mem_rdata` in the cycle after the read address.
- R7: `new_ip` equals byte 4n, with byte 4n+1 as its high byte. `new_cs` equals byte 4n+2, with byte 4n+3 as its high byte.
- R8: `new_sp` equals the request stack pointer minus 6, modulo 2^16, while `done` is high.
- R9: `done` is high for exactly one cycle. That cycle is the 11th cycle after the accepting edge. `busy` falls in the cycle after `done`.
- R10: A request presented while `busy` is high is ignored. It causes no memory access and does not change any reported value.
- R11: `mem_wr` and `mem_rd` are never high together. Each interrupt entry makes exactly six writes and four reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Interrupt entry request |
| req_type | input | 8 | Interrupt type number |
| req_flags | input | 16 | Flags word to save |
| req_cs | input | 16 | Current code segment |
| req_ip | input | 16 | Address of the interrupt instruction |
| req_ss | input | 16 | Stack segment |
| req_sp | input | 16 | Stack pointer before entry |
| mem_addr | output | 20 | Physical byte address |
| mem_wr | output | 1 | Byte write strobe |
| mem_rd | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid the cycle after the read address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_cs | output | 16 | Code segment fetched from the vector |
| new_ip | output | 16 | Instruction pointer fetched from the vector |
| new_sp | output | 16 | Stack pointer after the pushes |

## Verification
`busy` is due one edge after acceptance. The stack writes appear on edges 1 to 6 and the vector reads on edges 7 to 10. The last vector byte is captured on edge 11, which is also where `done` rises. It falls on edge 12. The bench drives each request between edges, then steps one edge at a time and samples 1 ns after each edge. It requires `done` on exactly the 11th step and checks that `done` is gone on the next. The memory model logs every access, and the logged addresses and data are compared against values computed from the segment arithmetic for all 256 types and for stack offsets that wrap.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;
   // Sequencer phase: accept, push stack bytes, fetch vector bytes,
   // capture the last fetched byte, report.
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_PUSH  = 3'd1,
      PH_FETCH = 3'd2,
      PH_FIN   = 3'd3,
      PH_DONE  = 3'd4
   } phase_t;

   // Words saved on entry: flags, code segment, return address.
   localparam int unsigned PUSH_WORDS  = 3;
   // Words read from the vector table: offset then segment.
   localparam int unsigned FETCH_WORDS = 2;
endpackage

// File: rtl/int_entry_phys.sv
// Segment:offset to physical address with wrap at ADDR_W bits.
module int_entry_phys #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned ADDR_W    = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] phys
);
   localparam int unsigned SHIFTED_W = SEG_W + SEG_SHIFT;
   localparam int unsigned SUM_W     = ((SHIFTED_W > OFF_W) ? SHIFTED_W : OFF_W) + 1;

   generate
      if (SUM_W > ADDR_W) begin : g_wrap
         // Sum is wider than the bus: add in ADDR_W bits so it wraps.
         assign phys = (ADDR_W'(seg) << SEG_SHIFT) + ADDR_W'(off);
      end else begin : g_full
         // Bus holds the full sum: no wrap possible.
         logic [SUM_W-1:0] sum;
         assign sum  = (SUM_W'(seg) << SEG_SHIFT) + SUM_W'(off);
         assign phys = ADDR_W'(sum);
      end
   endgenerate
endmodule

// File: rtl/int_entry_ctrl.sv
// Phase and byte counter for the entry sequence.
module int_entry_ctrl
   import int_entry_pkg::*;
#(
   parameter int unsigned NPUSH  = 6,
   parameter int unsigned NFETCH = 4,
   parameter int unsigned CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             accept,
   output phase_t           phase,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] PUSH_LAST  = CNT_W'(NPUSH - 1);
   localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(NFETCH - 1);

   phase_t           phase_n;
   logic [CNT_W-1:0] cnt_n;

   assign accept = (phase == PH_IDLE) && req_valid;

   always_comb begin
      phase_n = phase;
      cnt_n   = cnt;
      unique case (phase)
         PH_IDLE: begin
            if (req_valid) begin
               phase_n = PH_PUSH;
               cnt_n   = '0;
            end
         end
         PH_PUSH: begin
            if (cnt == PUSH_LAST) begin
               phase_n = PH_FETCH;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         PH_FETCH: begin
            if (cnt == FETCH_LAST) begin
               phase_n = PH_FIN;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         PH_FIN:  phase_n = PH_DONE;
         PH_DONE: phase_n = PH_IDLE;
         default: begin
            phase_n = PH_IDLE;
            cnt_n   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         phase <= phase_n;
         cnt   <= cnt_n;
      end
   end
endmodule

// File: rtl/int_entry_vecasm.sv
// Collects vector bytes into little-endian words.
module int_entry_vecasm #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [BYTE_W-1:0] din,
   output logic [WORD_W-1:0] vec_ip,
   output logic [WORD_W-1:0] vec_cs
);
   logic [NBYTES*BYTE_W-1:0] vec_all;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_slot
         logic [BYTE_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (cap_en && (cap_idx == IDX_W'(i)))
               slot_q <= din;
         end
         // Byte at the lower address sits in the lower lane.
         assign vec_all[i*BYTE_W +: BYTE_W] = slot_q;
      end
   endgenerate

   assign vec_ip = vec_all[WORD_W-1:0];
   assign vec_cs = vec_all[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/int_entry_seq.sv
// Interrupt entry microsequencer: push return context, fetch vector.
module int_entry_seq
   import int_entry_pkg::*;
#(
   parameter int unsigned TYPE_W    = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned RET_STEP  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TYPE_W-1:0] req_type,
   input  logic [WORD_W-1:0] req_flags,
   input  logic [WORD_W-1:0] req_cs,
   input  logic [WORD_W-1:0] req_ip,
   input  logic [WORD_W-1:0] req_ss,
   input  logic [WORD_W-1:0] req_sp,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr,
   output logic              mem_rd,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] new_cs,
   output logic [WORD_W-1:0] new_ip,
   output logic [WORD_W-1:0] new_sp
);
   localparam int unsigned BPW    = WORD_W / BYTE_W;
   localparam int unsigned NPUSH  = PUSH_WORDS * BPW;
   localparam int unsigned NFETCH = FETCH_WORDS * BPW;
   localparam int unsigned CNT_W  = $clog2(NPUSH);
   localparam int unsigned FIDX_W = (NFETCH > 1) ? $clog2(NFETCH) : 1;

   // Elaboration-time parameter checks
   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_ratio
         $error("WORD_W must be a multiple of BYTE_W");
      end
      if (BPW < 1) begin : g_bad_bpw
         $error("WORD_W must be at least BYTE_W");
      end
      if (ADDR_W < TYPE_W + FIDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector table");
      end
      if (CNT_W < FIDX_W) begin : g_bad_cnt
         $error("counter narrower than fetch index");
      end
   endgenerate

   // Request capture
   logic              accept;
   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [TYPE_W-1:0] type_q;
   logic [WORD_W-1:0] flags_q, cs_q, ret_q, ss_q, sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q  <= '0;
         flags_q <= '0;
         cs_q    <= '0;
         ret_q   <= '0;
         ss_q    <= '0;
         sp_q    <= '0;
      end else if (accept) begin
         type_q  <= req_type;
         flags_q <= req_flags;
         cs_q    <= req_cs;
         ret_q   <= req_ip + WORD_W'(RET_STEP);
         ss_q    <= req_ss;
         sp_q    <= req_sp;
      end
   end

   int_entry_ctrl #(
      .NPUSH (NPUSH),
      .NFETCH(NFETCH),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .accept   (accept),
      .phase    (phase),
      .cnt      (cnt)
   );

   // Push byte order: descending addresses, word 0 (flags) first,
   // high lane of each word first.
   logic [PUSH_WORDS*WORD_W-1:0] push_words;
   logic [BYTE_W-1:0]            push_byte [NPUSH];

   assign push_words = {ret_q, cs_q, flags_q};

   generate
      for (genvar k = 0; k < NPUSH; k++) begin : g_push_lane
         localparam int unsigned WI   = k / BPW;
         localparam int unsigned LANE = BPW - 1 - (k % BPW);
         assign push_byte[k] = push_words[WI*WORD_W + LANE*BYTE_W +: BYTE_W];
      end
   endgenerate

   // Stack address: pre-decrement below the captured pointer.
   logic [WORD_W-1:0] push_off;
   logic [ADDR_W-1:0] push_addr;

   assign push_off = sp_q - WORD_W'(cnt) - WORD_W'(1);

   int_entry_phys #(
      .SEG_W    (WORD_W),
      .OFF_W    (WORD_W),
      .SEG_SHIFT(SEG_SHIFT),
      .ADDR_W   (ADDR_W)
   ) u_stack_phys (
      .seg (ss_q),
      .off (push_off),
      .phys(push_addr)
   );

   // Vector address: segment 0, entry n at n * NFETCH.
   logic [ADDR_W-1:0] fetch_addr;
   assign fetch_addr = ADDR_W'(type_q) * ADDR_W'(NFETCH) + ADDR_W'(cnt);

   assign mem_wr    = (phase == PH_PUSH);
   assign mem_rd    = (phase == PH_FETCH);
   assign mem_wdata = mem_wr ? push_byte[cnt] : '0;

   always_comb begin
      unique case (phase)
         PH_PUSH:  mem_addr = push_addr;
         PH_FETCH: mem_addr = fetch_addr;
         default:  mem_addr = '0;
      endcase
   end

   // Read data returns one cycle after the address.
   logic              cap_en_q;
   logic [FIDX_W-1:0] cap_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en_q  <= 1'b0;
         cap_idx_q <= '0;
      end else begin
         cap_en_q  <= (phase == PH_FETCH);
         cap_idx_q <= cnt[FIDX_W-1:0];
      end
   end

   int_entry_vecasm #(
      .BYTE_W(BYTE_W),
      .WORD_W(WORD_W),
      .NBYTES(NFETCH),
      .IDX_W (FIDX_W)
   ) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en_q),
      .cap_idx(cap_idx_q),
      .din    (mem_rdata),
      .vec_ip (new_ip),
      .vec_cs (new_cs)
   );

   assign busy   = (phase != PH_IDLE);
   assign done   = (phase == PH_DONE);
   assign new_sp = sp_q - WORD_W'(NPUSH);
endmodule

// File: rtl/int_entry_seq_chk.sv
// Property checker for int_entry_seq, attached by bind.
module int_entry_seq_chk #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NPUSH  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [WORD_W-1:0] req_sp,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wr,
   input logic              mem_rd,
   input logic              busy,
   input logic              done,
   input logic [WORD_W-1:0] new_sp
);
   logic [WORD_W-1:0] sp_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_cap <= '0;
      else if (!busy && req_valid)
         sp_cap <= req_sp;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_wr && !mem_rd));

   // R2
   start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R6
   fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R8
   new_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (new_sp == sp_cap - WORD_W'(NPUSH)));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(new_sp));

   // R11
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));
endmodule

bind int_entry_seq int_entry_seq_chk #(
   .ADDR_W(ADDR_W),
   .WORD_W(WORD_W),
   .NPUSH (NPUSH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_sp   (req_sp),
   .mem_addr (mem_addr),
   .mem_wr   (mem_wr),
   .mem_rd   (mem_rd),
   .busy     (busy),
   .done     (done),
   .new_sp   (new_sp)
);

// File: tb/int_entry_seq_tb.sv
module int_entry_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_type = '0;
   logic [15:0] req_flags = '0, req_cs = '0, req_ip = '0, req_ss = '0, req_sp = '0;
   logic [19:0] mem_addr;
   logic        mem_wr, mem_rd;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done;
   logic [15:0] new_cs, new_ip, new_sp;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   int_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
      .req_flags(req_flags), .req_cs(req_cs), .req_ip(req_ip),
      .req_ss(req_ss), .req_sp(req_sp), .mem_addr(mem_addr),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
   );

   // Byte memory model with access log
   logic [7:0]  mem [logic [19:0]];
   logic [19:0] wa_log [8];
   logic [7:0]  wd_log [8];
   logic [19:0] ra_log [8];
   int wn = 0;
   int rn = 0;

   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr] = mem_wdata;
         if (wn < 8) begin
            wa_log[wn] = mem_addr;
            wd_log[wn] = mem_wdata;
         end
         wn++;
      end
      if (mem_rd) begin
         mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
         if (rn < 8) ra_log[rn] = mem_addr;
         rn++;
      end
   end

   function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
      return ({4'h0, seg} << 4) + {4'h0, off};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input logic [7:0] t, input logic [15:0] fl,
                           input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] ss, input logic [15:0] sp,
                           input logic [15:0] vip, input logic [15:0] vcs,
                           input bit noise);
      logic [15:0] words [3];
      logic [19:0] vb;
      int n;
      vb = {12'h000, t} * 20'd4;
      mem[vb]            = vip[7:0];
      mem[vb + 20'd1]    = vip[15:8];
      mem[vb + 20'd2]    = vcs[7:0];
      mem[vb + 20'd3]    = vcs[15:8];
      words[0] = fl;
      words[1] = cs;
      words[2] = ip + 16'd2;

      @(negedge clk);
      wn = 0;
      rn = 0;
      req_valid = 1'b1;
      req_type = t; req_flags = fl; req_cs = cs; req_ip = ip; req_ss = ss; req_sp = sp;
      @(posedge clk);
      #1;
      chk(busy === 1'b1, "R2", "busy after accept", {31'd0, busy}, 32'd1);
      if (noise) begin
         // R10: different request held high during the whole sequence
         req_type = ~t; req_flags = ~fl; req_cs = ~cs; req_ip = ~ip;
         req_ss = ss ^ 16'h0F0F; req_sp = sp ^ 16'h1234;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!done && n < 40) begin
         @(posedge clk);
         #1;
         n++;
      end
      req_valid = 1'b0;
      chk(n == 11, "R9", "done latency", n, 32'd11);
      chk(new_ip == vip, "R7", "new_ip", {16'd0, new_ip}, {16'd0, vip});
      chk(new_cs == vcs, "R7", "new_cs", {16'd0, new_cs}, {16'd0, vcs});
      chk(new_sp == sp - 16'd6, "R8", "new_sp", {16'd0, new_sp}, {16'd0, sp - 16'd6});
      @(posedge clk);
      #1;
      chk(!done && !busy, "R9", "done one cycle then idle", {30'd0, done, busy}, 32'd0);
      chk(wn == 6 && rn == 4, noise ? "R10" : "R11", "access counts",
          (wn << 8) | rn, 32'h604);
      for (int k = 0; k < 6; k++) begin
         logic [15:0] off;
         logic [7:0]  eb;
         off = sp - 16'(k + 1);
         eb  = (k % 2 == 0) ? words[k/2][15:8] : words[k/2][7:0];
         chk(wa_log[k] == phys(ss, off), "R3/R5", "push address",
             {12'd0, wa_log[k]}, {12'd0, phys(ss, off)});
         chk(wd_log[k] == eb, "R4", "push byte", {24'd0, wd_log[k]}, {24'd0, eb});
      end
      for (int k = 0; k < 4; k++) begin
         chk(ra_log[k] == vb + 20'(k), "R6", "vector read address",
             {12'd0, ra_log[k]}, {12'd0, vb + 20'(k)});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: quiet during reset
      chk(!busy && !done && !mem_wr && !mem_rd, "R1", "reset outputs",
          {28'd0, busy, done, mem_wr, mem_rd}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(!busy && !mem_wr && !mem_rd, "R1", "idle outputs",
          {29'd0, busy, mem_wr, mem_rd}, 32'd0);

      // Worked example: stack at 1000:0200 -> 10200h, vector type 5 at 14h
      run_case(8'h05, 16'h1234, 16'h1000, 16'h2034, 16'h1000, 16'h0200,
               16'h3340, 16'h3427, 1'b0);
      chk(mem[20'h101FA] == 8'h36, "R4", "return ip low at 101FA",
          {24'd0, mem[20'h101FA]}, 32'h36);
      chk(mem[20'h101FF] == 8'h12, "R4", "flags high at 101FF",
          {24'd0, mem[20'h101FF]}, 32'h12);
      chk(mem[20'h101FC] == 8'h00 && mem[20'h101FD] == 8'h10, "R4", "cs at 101FC",
          {16'd0, mem[20'h101FD], mem[20'h101FC]}, 32'h1000);
      chk(phys(new_cs, new_ip) == 20'h375B0, "R5", "target physical address",
          {12'd0, phys(new_cs, new_ip)}, 32'h375B0);

      // Offset wrap below zero and physical wrap above 2^20
      run_case(8'h80, 16'hAAAA, 16'h5555, 16'hFFFF, 16'h2000, 16'h0003,
               16'hBEEF, 16'hCAFE, 1'b0);
      run_case(8'h81, 16'h0F0F, 16'hF0F0, 16'h0001, 16'hFFFF, 16'h0010,
               16'h0102, 16'h0304, 1'b0);
      run_case(8'h82, 16'h8001, 16'h7FFE, 16'hFFFE, 16'hF000, 16'h0000,
               16'h00FF, 16'hFF00, 1'b1);

      // Sweep of every interrupt type
      for (int t = 0; t < 256; t++) begin
         logic [15:0] tt;
         tt = 16'(t);
         run_case(8'(t), tt * 16'h0123, 16'h4000 + tt * 16'h0011, tt * 16'h0707 + 16'h0100,
                  16'h1000 + tt * 16'h0031, 16'h0400 + tt * 16'h0101,
                  {8'(t) ^ 8'h5A, 8'(t)}, {~8'(t), 8'(t) + 8'h33}, (t % 16) == 7);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule